// File: doc/BRIEF.md
# Bus Master Transaction Timeout Monitor

This block sits beside a bus master and watches the transaction that master has outstanding. If the target stalls for too long, the block raises a sticky unrecoverable-error flag. It has two independent watchdogs. The ready-wait watchdog counts clocks in which the master waits for the target's ready handshake. The retry watchdog counts clocks from the first retry termination of a transaction until that transaction either transfers data or is dropped. A second output, `err_cause`, reports which watchdog fired.

Software programs each limit through a byte-wide configuration port. The ready-wait limit is scaled by 32: the 8-bit register value forms bits 12:5 of a 13-bit count, and bits 4:0 are zero. The retry limit is the register value in bus clocks, with no scaling. A value of zero turns a watchdog off. The monitor takes a snapshot of both registers while the bus is idle. A write made during a transaction therefore applies only to the next transaction.

Top module: `txn_timeout_mon`

## Requirements
- R1: After a synchronous reset, the ready-timeout register (address 40h) reads 00h, the retry-timeout register (address 41h) reads 80h, the status register (address 42h) reads 00h, `err_flag` is 0 and `err_cause` is 00.
- R2: The registers at 40h and 41h are read/write through the configuration port. Reads are combinational on `cfg_addr`. A write to any address other than 40h, 41h and 42h has no effect, and a read of such an address returns 00h.
- R3: A waiting cycle is a cycle with `txn_active`=1, `tgt_ready`=0 and `retry_term`=0. After N×32 consecutive waiting cycles, where N is the nonzero ready-timeout value, `err_flag` is 1 from the next cycle on and `err_cause` is 01.
- R4: The ready-wait count returns to zero in any cycle that is not a waiting cycle. This happens when target ready is seen, when a retry occurs, or when the transaction ends.
- R5: With the ready-timeout register at 00h, no number of waiting cycles sets `err_flag`.
- R6: A retry cycle is a cycle in which `txn_active`=1 and either `retry_term`=1, or an earlier retry cycle was the previous cycle and `tgt_ready`=0. After M consecutive retry cycles, where M is the nonzero retry-timeout value, `err_flag` is set and `err_cause` is 10. The retry count runs on across repeated retry terminations.
- R7: With the retry-timeout register at 00h, no number of retry cycles sets `err_flag`.
- R8: The retry count returns to zero when the transaction completes (`tgt_ready`=1 with `retry_term`=0) or is abandoned (`txn_active`=0).
- R9: `err_flag` stays set until software writes 42h with bit 0 = 1. That write clears the flag and sets `err_cause` to 00. Writing 42h with bit 0 = 0 has no effect. Status register 42h reads bit 0 = `err_flag` and bits 2:1 = `err_cause`.
- R10: The cause of the first expiry is held while the flag is set. If both watchdogs expire in the same cycle, the cause is 01 (ready-wait).
- R11: A limit written while `txn_active`=1 does not change the transaction in progress. It applies to the next transaction that follows at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| txn_active | input | 1 | Master has a transaction outstanding |
| tgt_ready | input | 1 | Target ready handshake seen this cycle |
| retry_term | input | 1 | Target answered with a retry termination |
| err_flag | output | 1 | Sticky unrecoverable-error flag |
| err_cause | output | 2 | 00 none, 01 ready-wait expiry, 10 retry expiry |

## Verification
The hardest case to reach from the ports is both watchdogs expiring on the same clock edge. The two counts start under different conditions: a retry cycle does not count as a waiting cycle. The bench therefore opens a transaction with a single retry termination and then holds the target not-ready. It sets the retry limit to one more than the ready-wait limit, 129 against 4×32. With those settings, both counts reach their limits on cycle 129, so the R10 priority decides the cause. A second hard case is proving that a limit written during a transaction applies only later. To show this, the bench rewrites the ready limit in the middle of a wait and then checks that the expiry still lands on the old cycle count, and that the next transaction uses the new one.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    parameter int REG_W     = 8;
    parameter int RDY_SHIFT = 5;
    localparam int RDY_W    = REG_W + RDY_SHIFT;

    parameter logic [7:0] ADDR_RDY  = 8'h40;
    parameter logic [7:0] ADDR_RTY  = 8'h41;
    parameter logic [7:0] ADDR_STAT = 8'h42;

    parameter logic [REG_W-1:0] RDY_RESET = 8'h00;
    parameter logic [REG_W-1:0] RTY_RESET = 8'h80;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_READY = 2'd1,
        CAUSE_RETRY = 2'd2
    } cause_e;

    typedef struct packed {
        logic [REG_W-1:0] rdy;
        logic [REG_W-1:0] rty;
    } limits_t;

    // Expand the ready register into the 13-bit clock count.
    function automatic logic [RDY_W-1:0] rdy_limit(input logic [REG_W-1:0] r);
        return {r, {RDY_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/tmo_cfg_regs.sv
module tmo_cfg_regs
    import tmo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             txn_active,
    input  logic             err_q,
    input  cause_e           cause_q,
    output limits_t          regs_q,
    output limits_t          snap_q,
    output logic             clr_req
);
    limits_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr && cfg_addr == ADDR_RDY) regs_d.rdy = cfg_wdata;
        if (cfg_wr && cfg_addr == ADDR_RTY) regs_d.rty = cfg_wdata;
    end

    assign clr_req = cfg_wr && (cfg_addr == ADDR_STAT) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{rdy: RDY_RESET, rty: RTY_RESET};
            snap_q <= '{rdy: RDY_RESET, rty: RTY_RESET};
        end else begin
            regs_q <= regs_d;
            // Snapshot follows the registers only while the bus is idle.
            if (!txn_active) snap_q <= regs_d;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            ADDR_RDY:  cfg_rdata = regs_q.rdy;
            ADDR_RTY:  cfg_rdata = regs_q.rty;
            ADDR_STAT: cfg_rdata = {5'b0, cause_q, err_q};
            default:   cfg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/tmo_watchdog.sv
module tmo_watchdog #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_m1;

    assign lim_m1 = limit - W'(1);
    assign hit    = run && (limit != '0) && (cnt_q == lim_m1);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q < limit)
            cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/tmo_err_latch.sv
module tmo_err_latch
    import tmo_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rdy_hit,
    input  logic   rty_hit,
    input  logic   clr_req,
    output logic   err_q,
    output cause_e cause_q
);
    logic any_hit;
    assign any_hit = rdy_hit || rty_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (any_hit && (!err_q || clr_req)) begin
            err_q   <= 1'b1;
            cause_q <= rdy_hit ? CAUSE_READY : CAUSE_RETRY;
        end else if (clr_req && !any_hit) begin
            err_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end
    end
endmodule

// File: rtl/txn_timeout_mon.sv
module txn_timeout_mon
    import tmo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       txn_active,
    input  logic       tgt_ready,
    input  logic       retry_term,
    output logic       err_flag,
    output logic [1:0] err_cause
);
    limits_t regs_q;
    limits_t snap_q;
    logic    clr_req;
    logic    err_q;
    cause_e  cause_q;
    logic    rdy_run, rty_run, rty_phase_q;
    logic    rdy_hit, rty_hit;

    tmo_cfg_regs u_regs (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .txn_active(txn_active),
        .err_q(err_q), .cause_q(cause_q),
        .regs_q(regs_q), .snap_q(snap_q), .clr_req(clr_req)
    );

    assign rdy_run = txn_active && !tgt_ready && !retry_term;
    assign rty_run = txn_active && (retry_term || (rty_phase_q && !tgt_ready));

    always_ff @(posedge clk) begin
        if (rst) rty_phase_q <= 1'b0;
        else     rty_phase_q <= rty_run;
    end

    tmo_watchdog #(.W(RDY_W)) u_rdy_wd (
        .clk(clk), .rst(rst), .run(rdy_run),
        .limit(rdy_limit(snap_q.rdy)), .hit(rdy_hit)
    );

    tmo_watchdog #(.W(REG_W)) u_rty_wd (
        .clk(clk), .rst(rst), .run(rty_run),
        .limit(snap_q.rty), .hit(rty_hit)
    );

    tmo_err_latch u_err (
        .clk(clk), .rst(rst), .rdy_hit(rdy_hit), .rty_hit(rty_hit),
        .clr_req(clr_req), .err_q(err_q), .cause_q(cause_q)
    );

    assign err_flag  = err_q;
    assign err_cause = cause_q;
endmodule

// File: rtl/txn_timeout_mon_chk.sv
module txn_timeout_mon_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic [7:0] cfg_addr,
    input logic [7:0] cfg_wdata,
    input logic       txn_active,
    input logic       err_flag,
    input logic [1:0] err_cause,
    input logic       rdy_hit,
    input logic       rty_hit,
    input logic [7:0] rdy_reg,
    input logic [7:0] rty_reg
);
    logic clr_w;
    assign clr_w = cfg_wr && cfg_addr == 8'h42 && cfg_wdata[0];

    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (rdy_reg == 8'h00 && rty_reg == 8'h80 && !err_flag && err_cause == 2'd0));

    p_wr_ready_reg_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == 8'h40) |=> rdy_reg == $past(cfg_wdata));

    p_no_hit_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !txn_active |-> (!rdy_hit && !rty_hit));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr_w) |=> err_flag);

    p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (err_flag && clr_w && !rdy_hit && !rty_hit) |=> (!err_flag && err_cause == 2'd0));

    p_cause_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr_w) |=> $stable(err_cause));

    p_tie_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (!err_flag && rdy_hit) |=> (err_flag && err_cause == 2'd1));

    p_retry_cause_r6: assert property (@(posedge clk) disable iff (rst)
        (!err_flag && rty_hit && !rdy_hit) |=> (err_flag && err_cause == 2'd2));

    p_cause_none_r9: assert property (@(posedge clk) disable iff (rst)
        !err_flag |-> err_cause == 2'd0);
endmodule

bind txn_timeout_mon txn_timeout_mon_chk u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .txn_active(txn_active),
    .err_flag(err_flag), .err_cause(err_cause),
    .rdy_hit(rdy_hit), .rty_hit(rty_hit),
    .rdy_reg(regs_q.rdy), .rty_reg(regs_q.rty)
);

// File: tb/txn_timeout_mon_tb.sv
module txn_timeout_mon_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       txn_active = 1'b0;
    logic       tgt_ready = 1'b0;
    logic       retry_term = 1'b0;
    logic       err_flag;
    logic [1:0] err_cause;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    txn_timeout_mon u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .txn_active(txn_active), .tgt_ready(tgt_ready), .retry_term(retry_term),
        .err_flag(err_flag), .err_cause(err_cause)
    );

    // {write, address, write data, expected read-back}
    localparam int NV = 10;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h40, 8'h5A, 8'h5A},
        {1'b1, 8'h41, 8'hA5, 8'hA5},
        {1'b1, 8'h43, 8'hFF, 8'h00},
        {1'b0, 8'h40, 8'h00, 8'h5A},
        {1'b1, 8'h3F, 8'h11, 8'h00},
        {1'b0, 8'h41, 8'h00, 8'hA5},
        {1'b1, 8'h40, 8'h00, 8'h00},
        {1'b1, 8'h41, 8'h80, 8'h80},
        {1'b1, 8'h42, 8'h00, 8'h00},
        {1'b0, 8'h40, 8'h00, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input string req, input logic [7:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic go_idle();
        txn_active = 1'b0; tgt_ready = 1'b0; retry_term = 1'b0;
        tick();
    endtask

    task automatic clear_err();
        cfg_write(8'h42, 8'h01);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        ticks(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 err_flag", err_flag, 0);
        check("R1 err_cause", err_cause, 0);
        cfg_read("R1 rdy reg", 8'h40, 8'h00);
        cfg_read("R1 rty reg", 8'h41, 8'h80);
        cfg_read("R1 status", 8'h42, 8'h00);

        // R2 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) cfg_write(VEC[i][23:16], VEC[i][15:8]);
            cfg_read("R2 table", VEC[i][23:16], VEC[i][7:0]);
        end

        // R5 ready watchdog disabled (ready reg 00h)
        txn_active = 1'b1;
        ticks(300);
        check("R5 disabled", err_flag, 0);
        go_idle();

        // R3 ready limit 1*32
        cfg_write(8'h40, 8'h01);
        txn_active = 1'b1;
        ticks(31);
        check("R3 before limit", err_flag, 0);
        tick();
        check("R3 at limit", err_flag, 1);
        check("R3 cause", err_cause, 1);
        cfg_read("R9 status", 8'h42, 8'h03);
        // R9 writing 0 leaves flag
        cfg_write(8'h42, 8'h00);
        check("R9 write0 keeps", err_flag, 1);
        go_idle();
        check("R9 sticky after idle", err_flag, 1);
        clear_err();
        check("R9 cleared", err_flag, 0);
        check("R9 cause cleared", err_cause, 0);

        // R4 count cleared by ready and by txn end
        txn_active = 1'b1;
        ticks(31);
        tgt_ready = 1'b1; tick(); tgt_ready = 1'b0;
        ticks(31);
        retry_term = 1'b1; tick(); retry_term = 1'b0;
        cfg_write(8'h41, 8'h00);   // keep the retry watchdog quiet for this part
        go_idle();
        txn_active = 1'b1;
        ticks(31);
        check("R4 no expiry after restarts", err_flag, 0);
        tick();
        check("R4 fresh count expires", err_flag, 1);
        go_idle();
        clear_err();

        // R7 retry watchdog disabled
        cfg_write(8'h40, 8'h00);
        txn_active = 1'b1; retry_term = 1'b1;
        ticks(300);
        check("R7 disabled", err_flag, 0);
        go_idle();

        // R6 retry limit 4, continued across retries
        cfg_write(8'h41, 8'h04);
        txn_active = 1'b1;
        retry_term = 1'b1; tick();
        retry_term = 1'b0; tick();
        retry_term = 1'b1; tick();
        retry_term = 1'b0;
        check("R6 before limit", err_flag, 0);
        tick();
        check("R6 at limit", err_flag, 1);
        check("R6 cause", err_cause, 2);
        go_idle();
        clear_err();

        // R8 retry count cleared by completion and by abandon
        txn_active = 1'b1;
        retry_term = 1'b1; tick(); retry_term = 1'b0; ticks(2);
        tgt_ready = 1'b1; tick(); tgt_ready = 1'b0;
        retry_term = 1'b1; tick(); retry_term = 1'b0; ticks(2);
        go_idle();
        txn_active = 1'b1;
        retry_term = 1'b1; tick(); retry_term = 1'b0; ticks(2);
        check("R8 no expiry", err_flag, 0);
        go_idle();

        // R10 tie: ready 4*32 and retry 129 expire together
        cfg_write(8'h40, 8'h04);
        cfg_write(8'h41, 8'h81);
        txn_active = 1'b1;
        retry_term = 1'b1; tick(); retry_term = 1'b0;
        ticks(127);
        check("R10 before tie", err_flag, 0);
        tick();
        check("R10 tie flag", err_flag, 1);
        check("R10 tie cause", err_cause, 1);
        ticks(5);
        check("R10 cause held", err_cause, 1);
        go_idle();
        clear_err();

        // R11 write during transaction applies to next one
        cfg_write(8'h41, 8'h00);
        cfg_write(8'h40, 8'h01);
        txn_active = 1'b1;
        ticks(4);
        cfg_write(8'h40, 8'h02);
        ticks(26);
        check("R11 old limit pending", err_flag, 0);
        tick();
        check("R11 old limit used", err_flag, 1);
        go_idle();
        clear_err();
        txn_active = 1'b1;
        ticks(63);
        check("R11 new limit pending", err_flag, 0);
        tick();
        check("R11 new limit used", err_flag, 1);
        go_idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule